// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a small synchronous static memory with a flow-through read path and no dead cycles when the bus turns around. The rising clock edge captures every control and address input. Read data comes combinationally out of the array during the cycle that follows that edge. Write data is taken one edge after its address, so a write and a read can follow each other on every clock without an idle slot between them.

A clock enable freezes the whole block. While it is low, the current cycle simply lasts longer. Three synchronous chip selects of mixed polarity qualify each new access. Per-lane write strobes mask the bytes of a word. An advance/load input either starts a new access or steps the two low address bits through a burst of four, in linear or interleaved order. A static mode input picks that order. An output-enable input gates the read data drive at any time, and the drive is also withheld during the data phase of every write.

The data bus is modelled as a data vector plus a drive flag. When the drive flag is low, the bus is released and the data vector reads as all zeros.

Top module: `zbt_flow_sram`

## Requirements
- R1: With `clk_en` high, a load (`ld_adv`=1, chip selects active, `wr_en`=0) captured at edge N places the word at `addr` on `dout` with `dout_drive`=1 in the cycle after edge N. No further register stage is involved.
- R2: While `clk_en` is low at an edge, that edge changes nothing. No burst step is taken, no write data is stored, and `dout`/`dout_drive` keep their values as long as `out_en` stays high.
- R3: A write loaded at edge N stores `din` as sampled at edge N+1. A read of the same address loaded at edge N+1 returns the newly written word in the next cycle, and reads and writes may alternate on every edge.
- R4: Lane k covers `din`/`dout` bits [9k+8:9k]. A write changes lane k only if `lane_wr[k]`=1 at the edge that captured that write's address. All other lanes keep their contents, and `lane_wr`=0000 stores nothing.
- R5: A load is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination gives a deselect cycle: no drive follows it and no write is stored.
- R6: `dout_drive`=1 only during the data phase of a selected read with `out_en`=1. It is 0 during the data phase of a write, and whenever it is 0, `dout` is all zeros.
- R7: `ld_adv`=0 with `clk_en` high steps a 2-bit counter k (0 at a load) and keeps the upper address bits of the load. The low two bits become (start+k) mod 4 when `burst_ilv`=0, and start XOR k when `burst_ilv`=1.
- R8: A burst step inherits the selection and the read/write direction of the load that began the burst. The chip selects and `wr_en` are ignored on a burst step, while `lane_wr` is taken afresh on each write step.
- R9: After reset, no access is pending and no burst is selected. `dout_drive` is 0, and a burst step taken before any load is a deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable. Low stretches the current cycle |
| ld_adv | input | 1 | 1 loads a new access, 0 steps the current burst |
| wr_en | input | 1 | 1 marks a loaded access as a write |
| lane_wr | input | LANES (4) | Per-lane write strobes, active high |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en | input | 1 | Asynchronous output enable, active high |
| addr | input | ADDR_W (8) | Word address |
| din | input | LANES*LANE_W (36) | Write data, sampled one edge after its address |
| dout | output | LANES*LANE_W (36) | Read data, zero when not driven |
| dout_drive | output | 1 | High when the block drives the data bus |

## Verification
A wrong pending-access register shows up at once. The drive flag or the returned word is wrong in the very cycle after the edge that captured the access, because nothing stands between that register and the outputs. A wrong burst counter or inherited direction is exposed on the first step of a burst, which reads a neighbouring word or drives during a write. A lane mask, data phase or stall applied wrongly corrupts the array silently. The reference model then catches it on the next read of that address, which the bench makes within a few cycles in the directed parts and through a full-array fill before the random mix.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    // Kind of access that is in its data phase
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits of burst step k from a start value
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] k,
                                             input logic       ilv);
        return ilv ? (start ^ k) : (start + k);
    endfunction

endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              ld_adv,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_wr,
    input  logic              cs_ok,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op_q,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LANES-1:0]  cmd_lanes
);

    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic              sel;    // burst selected
        logic              wr;     // burst direction
        logic [ADDR_W-1:0] base;   // load address
        logic [1:0]        k;      // step counter
        op_e               op;     // access in data phase
        logic [ADDR_W-1:0] a;      // its address
        logic [LANES-1:0]  ln;     // its lane strobes
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (ld_adv) begin
                st_d.sel  = cs_ok;
                st_d.wr   = wr_en;
                st_d.base = addr;
                st_d.k    = 2'd0;
                st_d.a    = addr;
            end else begin
                st_d.k = st_q.k + 2'd1;
                st_d.a = {st_q.base[ADDR_W-1 -: HI_W],
                          burst_low(st_q.base[1:0], st_d.k, burst_ilv)};
            end
            st_d.ln = lane_wr;
            if (!st_d.sel)    st_d.op = OP_IDLE;
            else if (st_d.wr) st_d.op = OP_WRITE;
            else              st_d.op = OP_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel: 1'b0, wr: 1'b0, base: '0, k: 2'd0,
                      op: OP_IDLE, a: '0, ln: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign op_q      = st_q.op;
    assign cmd_addr  = st_q.a;
    assign cmd_lanes = st_q.ln;

    // R7: a linear step moves the low bits by one and keeps the upper bits
    assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !ld_adv && !burst_ilv) |=>
            (cmd_addr[1:0] == $past(cmd_addr[1:0]) + 2'd1) &&
            (cmd_addr[ADDR_W-1:2] == $past(cmd_addr[ADDR_W-1:2])));

    // R8: a burst step keeps the kind of access of its burst
    assert_step_inherit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !ld_adv) |=> (op_q == $past(op_q)));

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wlanes,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wlanes[g]) begin
                mem_q[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem_q[raddr];
    end

endmodule

// File: rtl/zbt_flow_sram.sv
module zbt_flow_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    ld_adv,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        lane_wr,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    burst_ilv,
    input  logic                    out_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_drive
);

    localparam int DATA_W = LANES * LANE_W;

    logic              cs_ok;
    op_e               op_q;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  cmd_lanes;
    logic [DATA_W-1:0] rdata;
    logic              commit;

    assign cs_ok = !sel_a_n && sel_b && !sel_c_n;

    zbt_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .ld_adv    (ld_adv),
        .wr_en     (wr_en),
        .lane_wr   (lane_wr),
        .cs_ok     (cs_ok),
        .burst_ilv (burst_ilv),
        .addr      (addr),
        .op_q      (op_q),
        .cmd_addr  (cmd_addr),
        .cmd_lanes (cmd_lanes)
    );

    // The write data phase ends at the next enabled edge
    assign commit = rst_n && clk_en && (op_q == OP_WRITE);

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk    (clk),
        .we     (commit),
        .waddr  (cmd_addr),
        .wlanes (cmd_lanes),
        .wdata  (din),
        .raddr  (cmd_addr),
        .rdata  (rdata)
    );

    assign dout_drive = out_en && (op_q == OP_READ);
    assign dout       = dout_drive ? rdata : '0;

    // R2: a stalled edge leaves the driven data untouched
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && out_en) |=> (!out_en || $stable(dout)));

    // R5: a deselected load is followed by a released bus
    assert_deselect_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && ld_adv && !cs_ok) |=> !dout_drive);

    // R6: the data phase of a write never drives the bus
    assert_write_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && ld_adv && cs_ok && wr_en) |=> !dout_drive);

    // R1: a selected read load drives the bus in the next cycle when enabled
    assert_read_flow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && ld_adv && cs_ok && !wr_en) |=> (dout_drive == out_en));

endmodule

// File: tb/tb_zbt_flow_sram.sv
module tb_zbt_flow_sram;

    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam logic [2:0] CS_OK = 3'b010; // {sel_a_n, sel_b, sel_c_n}

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0, ld_adv = 1'b1, wr_en = 1'b0;
    logic [NL-1:0] lane_wr = '0;
    logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic          burst_ilv = 1'b0, out_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_drive;

    always #2 clk = ~clk;

    zbt_flow_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ld_adv(ld_adv),
        .wr_en(wr_en), .lane_wr(lane_wr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .burst_ilv(burst_ilv), .out_en(out_en),
        .addr(addr), .din(din), .dout(dout), .dout_drive(dout_drive)
    );

    // Reference model state
    logic [DW-1:0] rmem [0:(1<<AW)-1];
    bit            p_act, p_wr;
    int            p_addr;
    logic [NL-1:0] p_ln;
    bit            b_sel, b_wr;
    int            b_base, b_k;
    bit            ilv_g;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    function automatic logic [DW-1:0] pat(input int a);
        return {4'(a), 32'(a * 32'h9E3779B1)};
    endfunction

    task automatic compare(input string tag);
        bit            exp_drv;
        logic [DW-1:0] exp_d;
        exp_drv = p_act && !p_wr && out_en;
        exp_d   = exp_drv ? rmem[p_addr] : '0;
        checks++;
        if (dout_drive !== exp_drv || dout !== exp_d) begin
            fails++;
            $display("FAIL %s: drive %b data %h, expected drive %b data %h",
                     tag, dout_drive, dout, exp_drv, exp_d);
        end
    endtask

    // Drive one cycle's inputs, pass the edge, update the model, compare
    task automatic step(input bit ce, input bit la, input bit we,
                        input logic [NL-1:0] ln, input logic [2:0] cs,
                        input int a, input logic [DW-1:0] d,
                        input bit oe, input string tag);
        int lo;
        clk_en = ce; ld_adv = la; wr_en = we; lane_wr = ln;
        {sel_a_n, sel_b, sel_c_n} = cs;
        addr = AW'(a); din = d; out_en = oe; burst_ilv = ilv_g;
        @(posedge clk);
        if (ce) begin
            if (p_act && p_wr) begin
                for (int l = 0; l < NL; l++)
                    if (p_ln[l]) rmem[p_addr][l*LW +: LW] = d[l*LW +: LW];
            end
            if (la) begin
                b_sel = (cs == CS_OK); b_wr = we; b_base = a; b_k = 0;
            end else begin
                b_k = (b_k + 1) % 4;
            end
            lo = ilv_g ? ((b_base & 3) ^ b_k) : (((b_base & 3) + b_k) % 4);
            p_addr = (b_base & ~3) | lo;
            p_act = b_sel; p_wr = b_wr; p_ln = ln;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic ld(input bit we, input int a, input logic [DW-1:0] d,
                      input string tag);
        step(1'b1, 1'b1, we, 4'hF, CS_OK, a, d, 1'b1, tag);
    endtask

    task automatic adv(input logic [DW-1:0] d, input string tag);
        step(1'b1, 1'b0, 1'b0, 4'hF, 3'b111, 0, d, 1'b1, tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected end before %0d cycles", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        p_act = 0; p_wr = 0; p_addr = 0; p_ln = '0;
        b_sel = 0; b_wr = 0; b_base = 0; b_k = 0; ilv_g = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R9 reset state");
        rst_n = 1'b1;

        // R9: a burst step before any load is a deselect
        step(1'b1, 1'b0, 1'b0, 4'hF, CS_OK, 0, '0, 1'b1, "R9 step after reset");

        // R1/R3: fill every word with back-to-back writes
        ld(1'b1, 0, '0, "R3 fill");
        for (int a = 1; a < (1 << AW); a++) ld(1'b1, a, pat(a - 1), "R3 fill");
        ld(1'b0, 0, pat((1 << AW) - 1), "R1 read after fill");
        for (int a = 1; a < 16; a++) ld(1'b0, a, '0, "R1 flow-through read");

        // R3: write then read of the same address on consecutive edges
        for (int i = 0; i < 8; i++) begin
            ld(1'b1, 40 + i, 36'h123456789, "R3 write");
            ld(1'b0, 40 + i, ~pat(40 + i) ^ 36'(i), "R3 read after write");
        end

        // R4: lane masking
        step(1'b1, 1'b1, 1'b1, 4'b0101, CS_OK, 50, '0, 1'b1, "R4 masked write");
        ld(1'b0, 50, 36'hFFFFFFFFF, "R4 masked readback");
        step(1'b1, 1'b1, 1'b1, 4'b0000, CS_OK, 51, '0, 1'b1, "R4 empty mask");
        ld(1'b0, 51, 36'h0AAAAAAAA, "R4 empty mask readback");

        // R5: each wrong select gives a deselect, reads and writes alike
        step(1'b1, 1'b1, 1'b0, 4'hF, 3'b110, 5, '0, 1'b1, "R5 sel_a_n high");
        step(1'b1, 1'b1, 1'b0, 4'hF, 3'b000, 5, '0, 1'b1, "R5 sel_b low");
        step(1'b1, 1'b1, 1'b0, 4'hF, 3'b011, 5, '0, 1'b1, "R5 sel_c_n high");
        step(1'b1, 1'b1, 1'b1, 4'hF, 3'b111, 6, '0, 1'b1, "R5 deselected write");
        ld(1'b0, 6, 36'h555555555, "R5 deselected write left word");

        // R6: output enable and write data phase
        step(1'b1, 1'b1, 1'b0, 4'hF, CS_OK, 7, '0, 1'b0, "R6 out_en low");
        ld(1'b1, 8, '0, "R6 write data phase released");
        ld(1'b0, 8, 36'h00000ABCD, "R6 read after release");

        // R8/R7: linear write burst, then linear and interleaved read bursts
        ilv_g = 0;
        ld(1'b1, 8'h61, '0, "R8 burst write load");
        for (int i = 0; i < 3; i++) adv(36'h100000000 + 36'(i), "R8 burst write step");
        ld(1'b0, 8'h61, 36'h1000000FF, "R7 linear read load");
        for (int i = 0; i < 3; i++) adv('0, "R7 linear step");
        ilv_g = 1;
        ld(1'b0, 8'h62, '0, "R7 interleaved load");
        for (int i = 0; i < 3; i++) adv('0, "R7 interleaved step");
        ld(1'b1, 8'h83, '0, "R8 interleaved write load");
        for (int i = 0; i < 3; i++) adv(36'h200000000 + 36'(i), "R8 interleaved write step");
        ld(1'b0, 8'h80, 36'h2000000EE, "R7 read back");
        for (int i = 0; i < 3; i++) adv('0, "R7 read back step");
        ilv_g = 0;

        // R2: stalls mid-burst and inside a write data phase
        ld(1'b0, 8'h70, '0, "R2 burst load");
        adv('0, "R2 first step");
        for (int i = 0; i < 3; i++)
            step(1'b0, 1'b1, 1'b1, 4'hF, CS_OK, 9, 36'hDEADBEEF0, 1'b1, "R2 stalled");
        adv('0, "R2 step after stall");
        ld(1'b1, 8'h72, '0, "R2 write load");
        for (int i = 0; i < 2; i++)
            step(1'b0, 1'b0, 1'b0, 4'hF, CS_OK, 3, 36'hBADBADBAD, 1'b1, "R2 stalled write");
        ld(1'b0, 8'h72, 36'h0CAFE0001, "R2 write after stall");

        // R3: random mix of loads, steps, stalls and selects
        for (int i = 0; i < 600; i++) begin
            bit            ce, la, we, oe;
            logic [2:0]    cs;
            logic [NL-1:0] ln;
            ce = ($urandom % 10) != 0;
            la = ($urandom % 10) < 7;
            we = $urandom % 2;
            oe = ($urandom % 10) != 0;
            cs = (($urandom % 8) != 0) ? CS_OK : 3'($urandom);
            ln = NL'($urandom);
            if (i == 300) ilv_g = 1;
            step(ce, la, we, ln, cs, int'($urandom % (1 << AW)),
                 {4'($urandom), 32'($urandom)}, oe, "R3 random mix");
        end

        summary();
        $finish;
    end

endmodule